// File: doc/BRIEF.md
# Flash Converter Gray-Path Encoder

This block is the digital back end of a 5-bit flash converter. A bank of 31 comparators gives a thermometer vector. The block turns that vector into a Gray code and then into natural binary. It registers the result on the sample clock, so that unequal delays through the encode logic never reach the output.

Each Gray bit is the XOR of the thermometer bits at the positions where that Gray bit toggles. Because of this, an isolated wrong comparator (a bubble) changes only one Gray bit. The output code then lands next to the correct level and does not jump by a large amount.

The output stage is the only storage. It has a synchronous active-high reset. There are no states beyond the registered code.

Top module: `flash_gray_encoder`

## Requirements
- R1: The 5-bit output `code_o` is registered on the rising edge of `clk`. A new input shows at the output after exactly one rising edge, and the output holds its value between edges.
- R2: Bit p of `therm_i` is the comparator at reference step p+1, with bit 0 the lowest. A clean level k is bits 0..k-1 set and all others clear. For any such level, `code_o` equals k.
- R3: An all-ones `therm_i` (every comparator above its reference) gives code 31.
- R4: An all-zeros `therm_i` (input at or below the low reference) gives code 0.
- R5: Take a clean level L and invert one bit p. The output is the code whose Gray value, code^(code>>1), differs from the Gray value of L only in bit position ctz(p+1), where ctz is the count of trailing zeros.
- R6: While `rst` is high at a rising edge, `code_o` becomes 0 whatever `therm_i` holds.
- R7: For any `therm_i`, the Gray value of `code_o` is the XOR, over every set bit p, of a one placed at Gray position ctz(p+1). Binary bit 4 equals Gray bit 4, and each lower binary bit is the next higher binary bit XOR the Gray bit at its own position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| therm_i | input | 31 | Comparator thermometer vector, bit 0 lowest reference |
| code_o | output | 5 | Registered binary code |

## Verification
A wrong Gray bit mask shows up as a wrong output code for some clean level or some single-bubble pattern. It appears one edge after that pattern is applied. An error in the Gray-to-binary chain inverts every lower binary bit, so a sweep of all 32 clean levels exposes it at once. A missing or doubled output register shifts every result by one cycle. A latency check that samples just before and just after the edge catches this.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;

    localparam int DEF_CODE_W = 5;

    // Trailing-zero count of a positive value; returns 0 for 0.
    function automatic int tz_count(input int unsigned v);
        int n;
        n = 0;
        if (v != 0) begin
            for (int i = 0; i < 32; i++) begin
                if (v[i]) break;
                n++;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/flash_therm_to_gray.sv
module flash_therm_to_gray
    import flash_enc_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    localparam int THERM_W = (1 << CODE_W) - 1
) (
    input  logic [THERM_W-1:0] therm,
    output logic [CODE_W-1:0]  gray
);

    // Gray bit j toggles on reaching level m exactly when ctz(m) == j.
    // Level m is marked by thermometer bit m-1.
    always_comb begin
        for (int j = 0; j < CODE_W; j++) begin
            logic acc;
            acc = 1'b0;
            for (int p = 0; p < THERM_W; p++) begin
                if (tz_count(p + 1) == j) acc = acc ^ therm[p];
            end
            gray[j] = acc;
        end
    end

endmodule

// File: rtl/flash_gray_to_bin.sv
module flash_gray_to_bin #(
    parameter int CODE_W = 5
) (
    input  logic [CODE_W-1:0] gray,
    output logic [CODE_W-1:0] bin
);

    always_comb begin
        logic run;
        run = 1'b0;
        for (int i = CODE_W - 1; i >= 0; i--) begin
            run    = run ^ gray[i];
            bin[i] = run;
        end
    end

endmodule

// File: rtl/flash_out_reg.sv
module flash_out_reg #(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] d,
    output logic [CODE_W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

endmodule

// File: rtl/flash_gray_encoder.sv
module flash_gray_encoder
    import flash_enc_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W,
    localparam int THERM_W = (1 << CODE_W) - 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [THERM_W-1:0] therm_i,
    output logic [CODE_W-1:0]  code_o
);

    logic [CODE_W-1:0] gray_w;
    logic [CODE_W-1:0] bin_w;

    flash_therm_to_gray #(.CODE_W(CODE_W)) u_t2g (
        .therm (therm_i),
        .gray  (gray_w)
    );

    flash_gray_to_bin #(.CODE_W(CODE_W)) u_g2b (
        .gray (gray_w),
        .bin  (bin_w)
    );

    flash_out_reg #(.CODE_W(CODE_W)) u_oreg (
        .clk (clk),
        .rst (rst),
        .d   (bin_w),
        .q   (code_o)
    );

endmodule

// File: rtl/flash_gray_encoder_chk.sv
module flash_gray_encoder_chk #(
    parameter int CODE_W = 5,
    localparam int THERM_W = (1 << CODE_W) - 1
) (
    input logic               clk,
    input logic               rst,
    input logic [THERM_W-1:0] therm_i,
    input logic [CODE_W-1:0]  code_o
);

    // R6: reset forces zero on the next edge
    a_r6_reset_zero: assert property (@(posedge clk) rst |=> code_o == '0);

    // R3: all comparators high gives full scale
    a_r3_full_scale: assert property (@(posedge clk) disable iff (rst)
        (&therm_i) |=> code_o == {CODE_W{1'b1}});

    // R4: no comparator high gives zero
    a_r4_bottom: assert property (@(posedge clk) disable iff (rst)
        (therm_i == '0) |=> code_o == '0);

    // R2 / R1: a clean level appears one edge later as its count of ones
    a_r2_clean_level: assert property (@(posedge clk) disable iff (rst)
        ((therm_i & (therm_i + 1'b1)) == '0)
        |=> 32'(code_o) == 32'($countones($past(therm_i))));

    // R1: output holds between edges when reset is off and input is steady
    a_r1_steady: assert property (@(posedge clk) disable iff (rst)
        ($stable(therm_i) && !$past(rst)) |=> $stable(code_o));

endmodule

bind flash_gray_encoder flash_gray_encoder_chk #(.CODE_W(CODE_W)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .therm_i (therm_i),
    .code_o  (code_o)
);

// File: tb/flash_gray_encoder_tb.sv
module flash_gray_encoder_tb;

    localparam int CW = 5;
    localparam int TW = 31;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [TW-1:0] therm = '0;
    logic [CW-1:0] code;

    int n_checks = 0;
    int n_errors = 0;
    bit finished = 0;

    flash_gray_encoder u_dut (
        .clk     (clk),
        .rst     (rst),
        .therm_i (therm),
        .code_o  (code)
    );

    always #2 clk = ~clk;

    function automatic int ctz_b(input int v);
        int n;
        n = 0;
        while (v > 0 && (v % 2) == 0) begin
            v = v / 2;
            n++;
        end
        return n;
    endfunction

    function automatic logic [CW-1:0] g2b(input logic [CW-1:0] g);
        logic [CW-1:0] b;
        b = '0;
        for (int i = 0; i < CW; i++) b = b ^ (g >> i);
        return b;
    endfunction

    // R7 rule from the requirement text
    function automatic logic [CW-1:0] ref_code(input logic [TW-1:0] t);
        logic [CW-1:0] g;
        g = '0;
        for (int p = 0; p < TW; p++)
            if (t[p]) g = g ^ CW'(1 << ctz_b(p + 1));
        return g2b(g);
    endfunction

    function automatic logic [TW-1:0] level(input int k);
        logic [TW-1:0] t;
        t = '0;
        for (int p = 0; p < TW; p++) if (p < k) t[p] = 1'b1;
        return t;
    endfunction

    task automatic check(input logic [CW-1:0] exp, input string tag);
        n_checks++;
        if (code !== exp) begin
            n_errors++;
            $display("FAIL %s: code=%0d expected=%0d", tag, code, exp);
        end
    endtask

    // drive at falling edge, sample at the next falling edge
    task automatic apply(input logic [TW-1:0] t, input logic [CW-1:0] exp, input string tag);
        therm = t;
        @(negedge clk);
        check(exp, tag);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        therm = '1;
        @(negedge clk);
        check('0, "R6 reset with full input");
        @(negedge clk);
        check('0, "R6 reset held");
        rst = 1'b0;
        therm = '0;
        @(negedge clk);

        apply('0, 5'd0, "R4 all zeros");
        apply('1, 5'd31, "R3 all ones");

        for (int k = 0; k <= TW; k++)
            apply(level(k), CW'(k), "R2 clean level");

        // R1: latency, value unchanged before the edge and updated after it
        therm = level(9);
        @(negedge clk);
        therm = level(20);
        @(posedge clk);
        #0;
        @(negedge clk);
        check(5'd20, "R1 new value after edge");
        therm = level(3);
        #1;
        check(5'd20, "R1 held before edge");
        @(negedge clk);
        check(5'd3, "R1 one-edge latency");

        // R5: single bubble
        for (int k = 0; k <= TW; k++) begin
            for (int s = 0; s < 4; s++) begin
                int p;
                logic [TW-1:0] t;
                logic [CW-1:0] g;
                p = (k * 7 + s * 11) % TW;
                t = level(k);
                t[p] = ~t[p];
                g = CW'(k) ^ (CW'(k) >> 1);
                g = g ^ CW'(1 << ctz_b(p + 1));
                apply(t, g2b(g), "R5 single bubble");
            end
        end

        // R7: arbitrary patterns
        for (int i = 0; i < 300; i++) begin
            logic [TW-1:0] t;
            t = TW'($urandom());
            apply(t, ref_code(t), "R7 random pattern");
        end

        // R6: mid-run reset overrides
        therm = '1;
        rst = 1'b1;
        @(negedge clk);
        check('0, "R6 mid-run reset");
        rst = 1'b0;
        @(negedge clk);
        check(5'd31, "R3 after reset release");

        finished = 1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule